// File: doc/BRIEF.md
# Write-Through Snoop Invalidation Unit

This block keeps one write-through cache coherent in a system where several processors share a single memory bus. Because every cache in the system writes through, every store in the system shows up as a write on that bus. The unit watches each bus write issued by another master. When the written line is held valid in the local tag store, the unit clears its valid bit, so that the local processor misses and refetches instead of reading stale data.

The unit owns the cache's tag and valid store and gives it two lookup ports. One port serves the local processor's reads. The other serves bus snooping. A fill port lets the cache install a line after a miss. Data storage, line fetching and replacement choice stay with the cache. The cache supplies the way to fill.

Addresses are split into tag, set index and byte offset. The offset takes the low `OFFS_W` bits, the index the next `IDX_W` bits, and the tag all remaining high bits. Lookups compare tag and index only. A region whose top `NC_W` address bits equal `NC_PREFIX` is shared and never cached. A count of invalidations is exposed for test.

Top module: `wt_snoop_inval`

## Requirements
- R1: After reset every line is invalid: `inv_count` reads 0 and every local read misses.
- R2: A fill to a cacheable address at index `addr[OFFS_W+IDX_W-1:OFFS_W]`, with tag `addr[ADDR_W-1:OFFS_W+IDX_W]`, in way `fill_way` makes local reads to any offset of that line hit from the next cycle on. A read with another tag at the same index misses.
- R3: A bus write with `bus_wr_valid`=1, `bus_wr_mid` not equal to `LOCAL_ID` and a cacheable address clears every valid way holding that line, whatever the offset. A local read of that line in the following cycle misses.
- R4: `inv_count` rises by exactly one, one cycle after each bus write that clears a line. It does not change for a write that finds no valid matching line, and it does not change in cycles without a bus write.
- R5: A bus write whose `bus_wr_mid` equals `LOCAL_ID` changes no line and leaves `inv_count` unchanged.
- R6: An address whose top `NC_W` bits equal `NC_PREFIX` is non-cacheable. A fill to such an address is ignored and leaves the line it would have replaced intact. A bus write to such an address leaves `inv_count` unchanged.
- R7: A local read in the same cycle as an invalidating bus write to the same line returns a miss. A read of a different line in that cycle is unaffected.
- R8: A fill in the same cycle as an invalidating bus write to the same line is dropped, and the line reads as a miss afterwards. A fill to a different line in that cycle takes effect together with the invalidation.
- R9: An invalidation clears only the matching line. Other ways at the same index and other indexes keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_valid | input | 1 | A write completes on the shared bus this cycle |
| bus_wr_mid | input | MID_W | Master ID of the bus writer |
| bus_wr_addr | input | ADDR_W | Byte address of the bus write |
| lcl_rd_valid | input | 1 | Local processor lookup this cycle |
| lcl_rd_addr | input | ADDR_W | Address of the local lookup |
| lcl_rd_hit | output | 1 | Local lookup hits a valid line (combinational) |
| fill_valid | input | 1 | Install a line this cycle |
| fill_addr | input | ADDR_W | Address of the line to install |
| fill_way | input | WAY_W | Way that receives the fill |
| inv_count | output | CNT_W | Number of lines invalidated by snooping |

## Verification
The checker watches every cycle. It confirms that own-master writes and non-cacheable writes never move the counter. It confirms that the counter steps by one exactly after an invalidation and stays still in cycles without a bus write. It confirms that a local read of a line being snooped, or just snooped, never hits. Several behaviours can only be shown by the bench's sweeps over all sets and ways: that fills land in the right slot, that the other way and other indexes survive an invalidation, that a non-cacheable fill leaves the old line intact, and that a fill colliding with a snoop of the same line is dropped.

// File: rtl/wtsnp_pkg.sv
package wtsnp_pkg;
   // Classification of one observed bus cycle
   typedef enum logic [1:0] {
      SNP_IDLE     = 2'd0,
      SNP_OWN      = 2'd1,
      SNP_UNCACHED = 2'd2,
      SNP_FOREIGN  = 2'd3
   } snp_kind_e;
endpackage

// File: rtl/wtsnp_region.sv
// Decides whether an address lies outside the shared non-cacheable window.
module wtsnp_region #(
   parameter int ADDR_W    = 12,
   parameter int NC_W      = 2,
   parameter int NC_PREFIX = 3
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              cacheable
);
   generate
      if (NC_W == 0) begin : g_all_cached
         logic unused_addr;
         assign unused_addr = ^addr;
         assign cacheable   = 1'b1;
      end else begin : g_window
         localparam logic [NC_W-1:0] PREFIX = NC_W'(NC_PREFIX);
         assign cacheable = (addr[ADDR_W-1 -: NC_W] != PREFIX);
      end
   endgenerate
endmodule

// File: rtl/wtsnp_filter.sv
// Sorts a bus cycle into idle, own, uncached or foreign.
module wtsnp_filter
   import wtsnp_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int MID_W     = 2,
   parameter int LOCAL_ID  = 1,
   parameter int NC_W      = 2,
   parameter int NC_PREFIX = 3
) (
   input  logic              valid,
   input  logic [MID_W-1:0]  mid,
   input  logic [ADDR_W-1:0] addr,
   output snp_kind_e         kind,
   output logic              act
);
   localparam logic [MID_W-1:0] OWN_ID = MID_W'(LOCAL_ID);

   logic cacheable;

   wtsnp_region #(
      .ADDR_W   (ADDR_W),
      .NC_W     (NC_W),
      .NC_PREFIX(NC_PREFIX)
   ) u_rgn (
      .addr     (addr),
      .cacheable(cacheable)
   );

   always_comb begin
      if (!valid)             kind = SNP_IDLE;
      else if (mid == OWN_ID) kind = SNP_OWN;
      else if (!cacheable)    kind = SNP_UNCACHED;
      else                    kind = SNP_FOREIGN;
   end

   assign act = (kind == SNP_FOREIGN);
endmodule

// File: rtl/wtsnp_tagstore.sv
// Valid and tag storage with two read ports, one fill port and one
// per-way invalidate port. A fill to a slot wins over a clear of it.
module wtsnp_tagstore #(
   parameter int WAYS  = 2,
   parameter int IDX_W = 3,
   parameter int TAG_W = 7,
   parameter int WAY_W = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        fill_en,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic [IDX_W-1:0]            fill_idx,
   input  logic [TAG_W-1:0]            fill_tag,
   input  logic [WAYS-1:0]             kill_vec,
   input  logic [IDX_W-1:0]            kill_idx,
   input  logic [IDX_W-1:0]            a_idx,
   output logic [WAYS-1:0]             a_vld,
   output logic [WAYS-1:0][TAG_W-1:0]  a_tag,
   input  logic [IDX_W-1:0]            b_idx,
   output logic [WAYS-1:0]             b_vld,
   output logic [WAYS-1:0][TAG_W-1:0]  b_tag
);
   localparam int SETS = 1 << IDX_W;

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_way
         logic [SETS-1:0]            vld_q;
         logic [SETS-1:0][TAG_W-1:0] tag_q;
         logic                       sel_fill;
         logic                       sel_kill;

         assign sel_fill = fill_en && (fill_way == WAY_W'(w));
         assign sel_kill = kill_vec[w];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= '0;
            end else begin
               if (sel_fill) begin
                  vld_q[fill_idx] <= 1'b1;
               end
               if (sel_kill && !(sel_fill && (fill_idx == kill_idx))) begin
                  vld_q[kill_idx] <= 1'b0;
               end
            end
         end

         always_ff @(posedge clk) begin
            if (sel_fill) begin
               tag_q[fill_idx] <= fill_tag;
            end
         end

         assign a_vld[w] = vld_q[a_idx];
         assign a_tag[w] = tag_q[a_idx];
         assign b_vld[w] = vld_q[b_idx];
         assign b_tag[w] = tag_q[b_idx];
      end
   endgenerate
endmodule

// File: rtl/wtsnp_match.sv
// Per-way tag comparator.
module wtsnp_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 7
) (
   input  logic [WAYS-1:0]            vld,
   input  logic [WAYS-1:0][TAG_W-1:0] tag,
   input  logic [TAG_W-1:0]           cmp_tag,
   output logic [WAYS-1:0]            hit_vec
);
   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_cmp
         assign hit_vec[w] = vld[w] && (tag[w] == cmp_tag);
      end
   endgenerate
endmodule

// File: rtl/wtsnp_counter.sv
module wtsnp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n)   count <= '0;
      else if (inc) count <= count + 1'b1;
   end
endmodule

// File: rtl/wt_snoop_inval.sv
module wt_snoop_inval
   import wtsnp_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int OFFS_W    = 2,
   parameter int IDX_W     = 3,
   parameter int WAYS      = 2,
   parameter int MID_W     = 2,
   parameter int LOCAL_ID  = 1,
   parameter int NC_W      = 2,
   parameter int NC_PREFIX = 3,
   parameter int CNT_W     = 16,
   localparam int WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_valid,
   input  logic [MID_W-1:0]  bus_wr_mid,
   input  logic [ADDR_W-1:0] bus_wr_addr,
   input  logic              lcl_rd_valid,
   input  logic [ADDR_W-1:0] lcl_rd_addr,
   output logic              lcl_rd_hit,
   input  logic              fill_valid,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [WAY_W-1:0]  fill_way,
   output logic [CNT_W-1:0]  inv_count
);
   localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
   localparam int LINE_W = ADDR_W - OFFS_W;

   generate
      if (OFFS_W < 0 || IDX_W < 1 || TAG_W < 1) begin : g_bad_split
         $error("address split leaves no room for a tag");
      end
      if (WAYS < 1) begin : g_bad_ways
         $error("WAYS must be at least 1");
      end
      if (NC_W < 0 || NC_W > TAG_W) begin : g_bad_nc
         $error("non-cacheable window must lie inside the tag");
      end
      if (LOCAL_ID < 0 || LOCAL_ID >= (1 << MID_W)) begin : g_bad_id
         $error("LOCAL_ID does not fit in MID_W bits");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   // Field split
   logic [IDX_W-1:0]  bus_idx, lcl_idx, fill_idx;
   logic [TAG_W-1:0]  bus_tag, lcl_tag, fill_tag;
   logic [LINE_W-1:0] bus_line, lcl_line, fill_line;

   assign bus_idx   = bus_wr_addr[OFFS_W +: IDX_W];
   assign lcl_idx   = lcl_rd_addr[OFFS_W +: IDX_W];
   assign fill_idx  = fill_addr[OFFS_W +: IDX_W];
   assign bus_tag   = bus_wr_addr[ADDR_W-1 -: TAG_W];
   assign lcl_tag   = lcl_rd_addr[ADDR_W-1 -: TAG_W];
   assign fill_tag  = fill_addr[ADDR_W-1 -: TAG_W];
   assign bus_line  = bus_wr_addr[ADDR_W-1 -: LINE_W];
   assign lcl_line  = lcl_rd_addr[ADDR_W-1 -: LINE_W];
   assign fill_line = fill_addr[ADDR_W-1 -: LINE_W];

   generate
      if (OFFS_W > 0) begin : g_offs
         logic unused_offs;
         assign unused_offs = ^{bus_wr_addr[OFFS_W-1:0], lcl_rd_addr[OFFS_W-1:0],
                                fill_addr[OFFS_W-1:0]};
      end
   endgenerate

   // Bus cycle classification
   snp_kind_e snp_kind;
   logic      snp_act;

   wtsnp_filter #(
      .ADDR_W   (ADDR_W),
      .MID_W    (MID_W),
      .LOCAL_ID (LOCAL_ID),
      .NC_W     (NC_W),
      .NC_PREFIX(NC_PREFIX)
   ) u_flt (
      .valid(bus_wr_valid),
      .mid  (bus_wr_mid),
      .addr (bus_wr_addr),
      .kind (snp_kind),
      .act  (snp_act)
   );

   // Fill qualification
   logic fill_cacheable;
   logic fill_do;

   wtsnp_region #(
      .ADDR_W   (ADDR_W),
      .NC_W     (NC_W),
      .NC_PREFIX(NC_PREFIX)
   ) u_fill_rgn (
      .addr     (fill_addr),
      .cacheable(fill_cacheable)
   );

   assign fill_do = fill_valid && fill_cacheable && !(snp_act && (fill_line == bus_line));

   // Tag store and comparators
   logic [WAYS-1:0]            lcl_vld, snp_vld;
   logic [WAYS-1:0][TAG_W-1:0] lcl_tags, snp_tags;
   logic [WAYS-1:0]            lcl_hit_vec, snp_hit_vec, kill_vec;
   logic                       snp_inv_evt;

   wtsnp_tagstore #(
      .WAYS (WAYS),
      .IDX_W(IDX_W),
      .TAG_W(TAG_W),
      .WAY_W(WAY_W)
   ) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .fill_en (fill_do),
      .fill_way(fill_way),
      .fill_idx(fill_idx),
      .fill_tag(fill_tag),
      .kill_vec(kill_vec),
      .kill_idx(bus_idx),
      .a_idx   (lcl_idx),
      .a_vld   (lcl_vld),
      .a_tag   (lcl_tags),
      .b_idx   (bus_idx),
      .b_vld   (snp_vld),
      .b_tag   (snp_tags)
   );

   wtsnp_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lcl_cmp (
      .vld    (lcl_vld),
      .tag    (lcl_tags),
      .cmp_tag(lcl_tag),
      .hit_vec(lcl_hit_vec)
   );

   wtsnp_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_snp_cmp (
      .vld    (snp_vld),
      .tag    (snp_tags),
      .cmp_tag(bus_tag),
      .hit_vec(snp_hit_vec)
   );

   assign kill_vec    = snp_act ? snp_hit_vec : '0;
   assign snp_inv_evt = |kill_vec;

   // The snoop wins a same-line collision with a local read
   assign lcl_rd_hit = lcl_rd_valid && (|lcl_hit_vec) && !(snp_act && (lcl_line == bus_line));

   wtsnp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (snp_inv_evt),
      .count(inv_count)
   );
endmodule

// File: rtl/wt_snoop_inval_chk.sv
module wt_snoop_inval_chk #(
   parameter int ADDR_W    = 12,
   parameter int OFFS_W    = 2,
   parameter int MID_W     = 2,
   parameter int LOCAL_ID  = 1,
   parameter int NC_W      = 2,
   parameter int NC_PREFIX = 3,
   parameter int CNT_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_valid,
   input logic [MID_W-1:0]  bus_wr_mid,
   input logic [ADDR_W-1:0] bus_wr_addr,
   input logic              lcl_rd_valid,
   input logic [ADDR_W-1:0] lcl_rd_addr,
   input logic              lcl_rd_hit,
   input logic [CNT_W-1:0]  inv_count,
   input logic              inv_evt
);
   localparam int LINE_W = ADDR_W - OFFS_W;

   logic own_wr, nc_wr, foreign_wr, same_line;

   assign own_wr = bus_wr_valid && (bus_wr_mid == MID_W'(LOCAL_ID));
   generate
      if (NC_W == 0) begin : g_no_nc
         assign nc_wr = 1'b0;
      end else begin : g_nc
         assign nc_wr = bus_wr_valid && (bus_wr_addr[ADDR_W-1 -: NC_W] == NC_W'(NC_PREFIX));
      end
   endgenerate
   assign foreign_wr = bus_wr_valid && !own_wr && !nc_wr;
   assign same_line  = lcl_rd_addr[ADDR_W-1 -: LINE_W] == bus_wr_addr[ADDR_W-1 -: LINE_W];

   // R5
   a_r5_own_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      own_wr |=> (inv_count == $past(inv_count)));

   // R6
   a_r6_uncached_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      nc_wr |=> (inv_count == $past(inv_count)));

   // R7
   a_r7_collision_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (foreign_wr && lcl_rd_valid && same_line) |-> !lcl_rd_hit);

   // R4
   a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      inv_evt |=> (inv_count == CNT_W'($past(inv_count) + 1'b1)));

   // R4
   a_r4_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_valid |=> $stable(inv_count));

   // R3
   a_r3_miss_after_kill: assert property (@(posedge clk) disable iff (!rst_n)
      (lcl_rd_valid && $past(inv_evt) &&
       (lcl_rd_addr[ADDR_W-1 -: LINE_W] == $past(bus_wr_addr[ADDR_W-1 -: LINE_W])))
      |-> !lcl_rd_hit);
endmodule

bind wt_snoop_inval wt_snoop_inval_chk #(
   .ADDR_W   (ADDR_W),
   .OFFS_W   (OFFS_W),
   .MID_W    (MID_W),
   .LOCAL_ID (LOCAL_ID),
   .NC_W     (NC_W),
   .NC_PREFIX(NC_PREFIX),
   .CNT_W    (CNT_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_wr_valid(bus_wr_valid),
   .bus_wr_mid  (bus_wr_mid),
   .bus_wr_addr (bus_wr_addr),
   .lcl_rd_valid(lcl_rd_valid),
   .lcl_rd_addr (lcl_rd_addr),
   .lcl_rd_hit  (lcl_rd_hit),
   .inv_count   (inv_count),
   .inv_evt     (snp_inv_evt)
);

// File: tb/wt_snoop_inval_bench.sv
`timescale 1ns/1ps
module wt_snoop_inval_bench;
   localparam int ADDR_W = 12;
   localparam int OFFS_W = 2;
   localparam int IDX_W  = 3;
   localparam int WAYS   = 2;
   localparam int MID_W  = 2;
   localparam int LCL_ID = 1;
   localparam int FOR_ID = 2;
   localparam int CNT_W  = 16;
   localparam int WAY_W  = 1;
   localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
   localparam int SETS   = 1 << IDX_W;
   localparam int NC_TAG = 96;   // top two tag bits = 2'b11

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_wr_valid;
   logic [MID_W-1:0]  bus_wr_mid;
   logic [ADDR_W-1:0] bus_wr_addr;
   logic              lcl_rd_valid;
   logic [ADDR_W-1:0] lcl_rd_addr;
   logic              lcl_rd_hit;
   logic              fill_valid;
   logic [ADDR_W-1:0] fill_addr;
   logic [WAY_W-1:0]  fill_way;
   logic [CNT_W-1:0]  inv_count;

   int n_run  = 0;
   int n_fail = 0;
   int exp_cnt = 0;
   bit done = 0;

   always #5 clk = ~clk;

   wt_snoop_inval #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .WAYS(WAYS),
      .MID_W(MID_W), .LOCAL_ID(LCL_ID), .NC_W(2), .NC_PREFIX(3), .CNT_W(CNT_W)
   ) u_wt_snoop_inval (
      .clk(clk), .rst_n(rst_n),
      .bus_wr_valid(bus_wr_valid), .bus_wr_mid(bus_wr_mid), .bus_wr_addr(bus_wr_addr),
      .lcl_rd_valid(lcl_rd_valid), .lcl_rd_addr(lcl_rd_addr), .lcl_rd_hit(lcl_rd_hit),
      .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_way(fill_way),
      .inv_count(inv_count)
   );

   function automatic logic [ADDR_W-1:0] mk(int t, int s, int o);
      return {TAG_W'(t), IDX_W'(s), OFFS_W'(o)};
   endfunction

   function automatic int tg(int w, int s);
      return w * 8 + s + 1;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One cycle of stimulus, applied at the falling edge; outputs sampled 2 ns later
   task automatic step(input bit bv, input int bm, input logic [ADDR_W-1:0] ba,
                       input bit rv, input logic [ADDR_W-1:0] ra,
                       input bit fv, input logic [ADDR_W-1:0] fa, input int fw);
      @(negedge clk);
      bus_wr_valid = bv;
      bus_wr_mid   = MID_W'(bm);
      bus_wr_addr  = ba;
      lcl_rd_valid = rv;
      lcl_rd_addr  = ra;
      fill_valid   = fv;
      fill_addr    = fa;
      fill_way     = WAY_W'(fw);
      #2;
   endtask

   task automatic idle();
      step(0, 0, '0, 0, '0, 0, '0, 0);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a);
      step(0, 0, '0, 1, a, 0, '0, 0);
   endtask

   task automatic fill(input logic [ADDR_W-1:0] a, input int w);
      step(0, 0, '0, 0, '0, 1, a, w);
   endtask

   task automatic bwr(input int mid, input logic [ADDR_W-1:0] a);
      step(1, mid, a, 0, '0, 0, '0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      bus_wr_valid = 0; bus_wr_mid = '0; bus_wr_addr = '0;
      lcl_rd_valid = 0; lcl_rd_addr = '0;
      fill_valid = 0; fill_addr = '0; fill_way = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle();
      chk("R1 count", int'(inv_count), 0);
      for (int w = 0; w < WAYS; w++)
         for (int s = 0; s < SETS; s++) begin
            rd(mk(tg(w, s), s, 0));
            chk("R1 read miss", int'(lcl_rd_hit), 0);
         end

      // R2: fill every slot, then sweep reads
      for (int w = 0; w < WAYS; w++)
         for (int s = 0; s < SETS; s++)
            fill(mk(tg(w, s), s, 0), w);
      for (int w = 0; w < WAYS; w++)
         for (int s = 0; s < SETS; s++) begin
            rd(mk(tg(w, s), s, s % 4));
            chk("R2 hit", int'(lcl_rd_hit), 1);
            rd(mk(tg(w, s) + 40, s, 1));
            chk("R2 other tag miss", int'(lcl_rd_hit), 0);
         end

      // R5: own-master write ignored
      bwr(LCL_ID, mk(tg(0, 0), 0, 2));
      rd(mk(tg(0, 0), 0, 0));
      chk("R5 line kept", int'(lcl_rd_hit), 1);
      chk("R5 count", int'(inv_count), exp_cnt);

      // R6: non-cacheable fill and write ignored
      fill(mk(NC_TAG, 0, 0), 0);
      rd(mk(tg(0, 0), 0, 0));
      chk("R6 old line intact", int'(lcl_rd_hit), 1);
      rd(mk(NC_TAG, 0, 0));
      chk("R6 nc read miss", int'(lcl_rd_hit), 0);
      bwr(FOR_ID, mk(NC_TAG, 0, 1));
      idle();
      chk("R6 count", int'(inv_count), exp_cnt);

      // R4: foreign write to an absent line
      bwr(FOR_ID, mk(50, 2, 0));
      idle();
      chk("R4 no match count", int'(inv_count), exp_cnt);
      rd(mk(tg(0, 2), 2, 0));
      chk("R4 no match line kept", int'(lcl_rd_hit), 1);

      // R7: collision with local read of the same line
      step(1, FOR_ID, mk(tg(0, 3), 3, 1), 1, mk(tg(0, 3), 3, 2), 0, '0, 0);
      chk("R7 same-line miss", int'(lcl_rd_hit), 0);
      exp_cnt++;
      rd(mk(tg(1, 3), 3, 0));
      chk("R9 other way kept", int'(lcl_rd_hit), 1);
      chk("R4 count after kill", int'(inv_count), exp_cnt);
      rd(mk(tg(0, 3), 3, 3));
      chk("R3 miss after kill", int'(lcl_rd_hit), 0);

      // R3/R9/R4 sweep over way 0
      for (int s = 0; s < SETS; s++) begin
         if (s != 3) begin
            bwr(FOR_ID, mk(tg(0, s), s, (s + 1) % 4));
            exp_cnt++;
            rd(mk(tg(0, s), s, s % 4));
            chk("R3 sweep miss", int'(lcl_rd_hit), 0);
            chk("R4 sweep count", int'(inv_count), exp_cnt);
            rd(mk(tg(1, s), s, 0));
            chk("R9 sweep other way", int'(lcl_rd_hit), 1);
         end
      end

      // R8: fill colliding with a snoop of the same line is dropped
      step(1, FOR_ID, mk(60, 2, 3), 0, '0, 1, mk(60, 2, 0), 0);
      rd(mk(60, 2, 1));
      chk("R8 dropped fill miss", int'(lcl_rd_hit), 0);
      chk("R8 count", int'(inv_count), exp_cnt);
      fill(mk(60, 2, 0), 0);
      rd(mk(60, 2, 1));
      chk("R8 later fill hit", int'(lcl_rd_hit), 1);

      // R8: fill of a different line in the same cycle takes effect
      step(1, FOR_ID, mk(tg(1, 4), 4, 0), 0, '0, 1, mk(61, 4, 0), 0);
      exp_cnt++;
      rd(mk(61, 4, 2));
      chk("R8 other fill hit", int'(lcl_rd_hit), 1);
      rd(mk(tg(1, 4), 4, 0));
      chk("R3 way1 killed", int'(lcl_rd_hit), 0);
      chk("R4 count", int'(inv_count), exp_cnt);

      // R7: read of a different line during a snoop is unaffected
      step(1, FOR_ID, mk(tg(1, 5), 5, 0), 1, mk(tg(1, 6), 6, 0), 0, '0, 0);
      chk("R7 other line hit", int'(lcl_rd_hit), 1);
      exp_cnt++;
      rd(mk(tg(1, 6), 6, 1));
      chk("R9 other index kept", int'(lcl_rd_hit), 1);
      chk("R4 final count", int'(inv_count), exp_cnt);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule